// File: doc/BRIEF.md
# Serial PHY PLL Power Sequencer

This block replaces a software driver for bringing a serial PHY's clock generator and power control up and down. It is a bus master on a single-beat register bus that reaches the PLL control space. It also owns the PHY power-control word. A power-up request first checks whether the PLL already reports lock. If it does not, the block picks divider settings from a small table, keyed by an exact match on the reference clock rate. It writes those settings into the PLL one field at a time by read-modify-write, starts the PLL, and polls for lock once per millisecond tick. On lock it switches the PHY transmit and receive paths on and records the reference rate in whole MHz.

A power-down request switches the transmit and receive paths off and sets the PLL idle bit. It then polls until the analog supply and oscillator both report that they are powered down. Each sequence ends with a one-cycle pulse: done, busy error or invalid configuration.

The divider table is taken from module parameters at elaboration. A parameter also sets the length of the millisecond tick in clock cycles.

Top module: `phy_pll_seq`

## Requirements
- R1: After a synchronous reset, `bus_req`, `done`, `busy_err` and `cfg_err` are 0 and `phy_pwr` is 0.
- R2: On power-up with status bit 1 clear and a reference rate that matches no table entry, `cfg_err` pulses and no bus write occurs.
- R3: On power-up with status bit 1 clear and a matching entry, exactly six writes occur, in this order, and each of the first five keeps every other bit of the register it was read from: N into 0x0C bits 8:1, DCO select into 0x10 bits 3:1, M into 0x0C bits 20:9, fractional M into 0x20 bits 17:0, sigma-delta into 0x14 bits 17:10, then 0x00000001 to 0x08.
- R4: The lock wait reads status 0x04 once per tick and accepts lock when bit 1 is set. After 100 polls without lock it pulses `busy_err` and leaves `phy_pwr` unchanged.
- R5: On lock, `phy_pwr` bits 21:14 become 0x03 and bits 31:22 become the reference rate divided by 1,000,000. Bits 13:0 are kept, and `done` pulses. Bits 21:14 only ever hold 0x00 or 0x03.
- R6: If status bit 1 is already set at power-up, no table lookup takes place. If 0x10 bit 0 is set, the only write is 0x10 with bit 0 cleared, followed by the lock wait. If 0x10 bit 0 is clear, no write occurs and the power word is updated at once.
- R7: Power-down first clears `phy_pwr` bits 21:14, keeping all other bits. It then writes 0x10 with bit 0 set and all other bits kept. It pulses `done` once status bits 16 and 15 are both set.
- R8: If status bits 16 and 15 are not both set after 100 power-down polls, `busy_err` pulses.
- R9: `up_req` and `down_req` arriving while a sequence runs have no effect on that sequence or afterwards.
- R10: `bus_req` stays high with `bus_we`, `bus_addr` and `bus_wdata` stable until `bus_ack`. Only one transfer is outstanding at a time.
- R11: `done`, `busy_err` and `cfg_err` are one-cycle pulses and never assert together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Power-up request, sampled while idle |
| down_req | input | 1 | Power-down request, sampled while idle |
| ref_hz | input | 32 | Reference clock frequency in Hz |
| bus_req | output | 1 | Register bus transfer request |
| bus_we | output | 1 | Transfer is a write |
| bus_addr | output | ADDR_W | Byte offset in the PLL control space |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transfer complete |
| phy_pwr | output | 32 | PHY power-control word |
| done | output | 1 | Sequence finished successfully |
| busy_err | output | 1 | Lock or power-down poll timed out |
| cfg_err | output | 1 | No divider entry for the reference rate |

## Verification
The bench uses a tick of 16 cycles instead of a full millisecond. With this tick, both 100-poll timeouts finish in a few thousand cycles, so the exact poll count can be compared against the limit. The bench builds a four-entry table covering 19.2, 20, 26 and 38.4 MHz and checks the read-modify-write results for each entry against random register contents. A model of the PLL registers with random acknowledge latency covers back-to-back transfers, a lock that arrives after a few polls, and analog parts that never report off.

// File: rtl/phy_pll_pkg.sv
package phy_pll_pkg;
  localparam int DATA_W = 32;

  // byte offsets inside the PLL control space
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_GO   = 8'h08;
  localparam logic [7:0] OFS_CFGA = 8'h0C;
  localparam logic [7:0] OFS_CFGB = 8'h10;
  localparam logic [7:0] OFS_CFGC = 8'h14;
  localparam logic [7:0] OFS_CFGD = 8'h20;

  // power word fields
  localparam int CMD_LSB  = 14;
  localparam int CMD_W    = 8;
  localparam int FREQ_LSB = 22;
  localparam int FREQ_W   = 10;

  typedef enum logic [4:0] {
    ST_IDLE, ST_STAT, ST_LUT, ST_CFG_RD, ST_CFG_WR, ST_GO,
    ST_SKIP_RD, ST_SKIP_WR, ST_WAIT_LOCK, ST_LOCK_POLL, ST_PWR_ON,
    ST_DN_WORD, ST_DN_RD, ST_DN_WR, ST_WAIT_OFF, ST_OFF_POLL
  } seq_state_t;

  typedef enum logic [1:0] {BUS_NONE, BUS_RD, BUS_WR} bus_op_t;

  function automatic logic [DATA_W-1:0] put_field(input logic [DATA_W-1:0] old,
                                                   input logic [DATA_W-1:0] val,
                                                   input int lsb, input int w);
    logic [DATA_W-1:0] mask;
    mask = ((DATA_W'(1) << w) - DATA_W'(1)) << lsb;
    return (old & ~mask) | ((val << lsb) & mask);
  endfunction
endpackage

// File: rtl/pll_rate_lut.sv
module pll_rate_lut #(
  parameter int ENTRIES = 4,
  parameter logic [ENTRIES-1:0][31:0] RATES = '0,
  parameter logic [ENTRIES-1:0][7:0]  DIV_N = '0,
  parameter logic [ENTRIES-1:0][11:0] DIV_M = '0,
  parameter logic [ENTRIES-1:0][17:0] DIV_MF = '0,
  parameter logic [ENTRIES-1:0][2:0]  DCO_SEL = '0,
  parameter logic [ENTRIES-1:0][7:0]  SD_VAL = '0
) (
  input  logic [31:0] rate,
  output logic        hit,
  output logic [7:0]  n,
  output logic [11:0] m,
  output logic [17:0] mf,
  output logic [2:0]  sel,
  output logic [7:0]  sd
);
  logic [ENTRIES-1:0] match;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      // a zero rate marks an unused slot
      assign match[g] = (RATES[g] != 32'd0) && (RATES[g] == rate);
    end
  endgenerate

  always_comb begin
    hit = 1'b0; n = '0; m = '0; mf = '0; sel = '0; sd = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1; n = DIV_N[i]; m = DIV_M[i]; mf = DIV_MF[i];
        sel = DCO_SEL[i]; sd = SD_VAL[i];
      end
    end
  end
endmodule

// File: rtl/pll_tick_timer.sv
module pll_tick_timer #(
  parameter int TICK_CYCLES = 125000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(TICK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/phy_pll_seq.sv
module phy_pll_seq
  import phy_pll_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int TICK_CYCLES = 125000,
  parameter int MAX_POLLS   = 100,
  parameter int ENTRIES     = 4,
  parameter logic [ENTRIES-1:0][31:0] RATES   = {32'd38400000, 32'd26000000, 32'd20000000, 32'd19200000},
  parameter logic [ENTRIES-1:0][7:0]  DIV_N   = {8'd15, 8'd12, 8'd7, 8'd7},
  parameter logic [ENTRIES-1:0][11:0] DIV_M   = {12'd1300, 12'd1250, 12'd1100, 12'd1000},
  parameter logic [ENTRIES-1:0][17:0] DIV_MF  = {18'd200000, 18'd0, 18'd12345, 18'd0},
  parameter logic [ENTRIES-1:0][2:0]  DCO_SEL = {3'd3, 3'd4, 3'd2, 3'd2},
  parameter logic [ENTRIES-1:0][7:0]  SD_VAL  = {8'd20, 8'd14, 8'd13, 8'd12}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_req,
  input  logic              down_req,
  input  logic [31:0]       ref_hz,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack,
  output logic [31:0]       phy_pwr,
  output logic              done,
  output logic              busy_err,
  output logic              cfg_err
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);
  localparam logic [2:0] STEP_LAST = 3'd4;

  seq_state_t state;
  logic [31:0] ref_q, rmw_q;
  logic [2:0]  step;
  logic [PW-1:0] polls;
  logic [7:0]  n_q, sd_q;
  logic [11:0] m_q;
  logic [17:0] mf_q;
  logic [2:0]  sel_q;

  logic        lut_hit;
  logic [7:0]  lut_n, lut_sd;
  logic [11:0] lut_m;
  logic [17:0] lut_mf;
  logic [2:0]  lut_sel;
  logic        tick, tmr_run, xfer;

  pll_rate_lut #(
    .ENTRIES(ENTRIES), .RATES(RATES), .DIV_N(DIV_N), .DIV_M(DIV_M),
    .DIV_MF(DIV_MF), .DCO_SEL(DCO_SEL), .SD_VAL(SD_VAL)
  ) u_lut (
    .rate(ref_q), .hit(lut_hit), .n(lut_n), .m(lut_m),
    .mf(lut_mf), .sel(lut_sel), .sd(lut_sd)
  );

  assign tmr_run = (state == ST_WAIT_LOCK) || (state == ST_WAIT_OFF);

  pll_tick_timer #(.TICK_CYCLES(TICK_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .run(tmr_run), .tick(tick)
  );

  // field selected by the current programming step
  logic [7:0]  f_addr;
  logic [31:0] f_val;
  int          f_lsb, f_w;
  always_comb begin
    unique case (step)
      3'd0:    begin f_addr = OFS_CFGA; f_val = 32'(n_q);   f_lsb = 1;  f_w = 8;  end
      3'd1:    begin f_addr = OFS_CFGB; f_val = 32'(sel_q); f_lsb = 1;  f_w = 3;  end
      3'd2:    begin f_addr = OFS_CFGA; f_val = 32'(m_q);   f_lsb = 9;  f_w = 12; end
      3'd3:    begin f_addr = OFS_CFGD; f_val = 32'(mf_q);  f_lsb = 0;  f_w = 18; end
      default: begin f_addr = OFS_CFGC; f_val = 32'(sd_q);  f_lsb = 10; f_w = 8;  end
    endcase
  end

  // bus transfer wanted in the current state
  bus_op_t     op;
  logic [7:0]  op_addr;
  logic [31:0] op_data;
  always_comb begin
    op = BUS_NONE; op_addr = OFS_STAT; op_data = '0;
    unique case (state)
      ST_STAT, ST_LOCK_POLL, ST_OFF_POLL: op = BUS_RD;
      ST_CFG_RD:  begin op = BUS_RD; op_addr = f_addr; end
      ST_CFG_WR:  begin op = BUS_WR; op_addr = f_addr; op_data = put_field(rmw_q, f_val, f_lsb, f_w); end
      ST_GO:      begin op = BUS_WR; op_addr = OFS_GO; op_data = 32'd1; end
      ST_SKIP_RD, ST_DN_RD: begin op = BUS_RD; op_addr = OFS_CFGB; end
      ST_SKIP_WR: begin op = BUS_WR; op_addr = OFS_CFGB; op_data = rmw_q & ~32'd1; end
      ST_DN_WR:   begin op = BUS_WR; op_addr = OFS_CFGB; op_data = rmw_q | 32'd1; end
      default: ;
    endcase
  end

  assign xfer = bus_req && bus_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; bus_req <= 1'b0; bus_we <= 1'b0; bus_addr <= '0;
      bus_wdata <= '0; phy_pwr <= '0; done <= 1'b0; busy_err <= 1'b0;
      cfg_err <= 1'b0; ref_q <= '0; rmw_q <= '0; step <= '0; polls <= '0;
      n_q <= '0; m_q <= '0; mf_q <= '0; sel_q <= '0; sd_q <= '0;
    end else begin
      done <= 1'b0; busy_err <= 1'b0; cfg_err <= 1'b0;
      if (xfer) bus_req <= 1'b0;
      else if (!bus_req && op != BUS_NONE) begin
        bus_req   <= 1'b1;
        bus_we    <= (op == BUS_WR);
        bus_addr  <= ADDR_W'(op_addr);
        bus_wdata <= op_data;
      end
      unique case (state)
        ST_IDLE: begin
          if (up_req) begin ref_q <= ref_hz; state <= ST_STAT; end
          else if (down_req) state <= ST_DN_WORD;
        end
        ST_STAT: if (xfer) state <= bus_rdata[1] ? ST_SKIP_RD : ST_LUT;
        ST_LUT: begin
          if (lut_hit) begin
            n_q <= lut_n; m_q <= lut_m; mf_q <= lut_mf; sel_q <= lut_sel; sd_q <= lut_sd;
            step <= '0; state <= ST_CFG_RD;
          end else begin
            cfg_err <= 1'b1; state <= ST_IDLE;
          end
        end
        ST_CFG_RD: if (xfer) begin rmw_q <= bus_rdata; state <= ST_CFG_WR; end
        ST_CFG_WR: if (xfer) begin
          if (step == STEP_LAST) state <= ST_GO;
          else begin step <= step + 1'b1; state <= ST_CFG_RD; end
        end
        ST_GO: if (xfer) begin polls <= '0; state <= ST_WAIT_LOCK; end
        ST_SKIP_RD: if (xfer) begin
          rmw_q <= bus_rdata;
          state <= bus_rdata[0] ? ST_SKIP_WR : ST_PWR_ON;
        end
        ST_SKIP_WR: if (xfer) begin polls <= '0; state <= ST_WAIT_LOCK; end
        ST_WAIT_LOCK: if (tick) state <= ST_LOCK_POLL;
        ST_LOCK_POLL: if (xfer) begin
          if (bus_rdata[1]) state <= ST_PWR_ON;
          else if (polls == POLL_LAST) begin busy_err <= 1'b1; state <= ST_IDLE; end
          else begin polls <= polls + 1'b1; state <= ST_WAIT_LOCK; end
        end
        ST_PWR_ON: begin
          phy_pwr[CMD_LSB +: CMD_W]   <= CMD_W'(3);
          phy_pwr[FREQ_LSB +: FREQ_W] <= FREQ_W'(ref_q / 32'd1000000);
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        ST_DN_WORD: begin
          phy_pwr[CMD_LSB +: CMD_W] <= '0;
          state <= ST_DN_RD;
        end
        ST_DN_RD: if (xfer) begin rmw_q <= bus_rdata; state <= ST_DN_WR; end
        ST_DN_WR: if (xfer) begin polls <= '0; state <= ST_WAIT_OFF; end
        ST_WAIT_OFF: if (tick) state <= ST_OFF_POLL;
        ST_OFF_POLL: if (xfer) begin
          if (bus_rdata[16] && bus_rdata[15]) begin done <= 1'b1; state <= ST_IDLE; end
          else if (polls == POLL_LAST) begin busy_err <= 1'b1; state <= ST_IDLE; end
          else begin polls <= polls + 1'b1; state <= ST_WAIT_OFF; end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_pll_seq_chk.sv
module phy_pll_seq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       phy_pwr,
  input logic              done,
  input logic              busy_err,
  input logic              cfg_err
);
  // R10: a pending request holds its command until acknowledged
  assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we));

  // R11: outcome flags never coincide
  assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, busy_err, cfg_err}));

  // R11: done lasts one cycle
  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: the on/off command field only takes its two legal codes
  assert_cmd_legal_R5: assert property (@(posedge clk) disable iff (rst)
    (phy_pwr[21:14] == 8'h00) || (phy_pwr[21:14] == 8'h03));

  // R2: a configuration error leaves the power word alone
  assert_cfgerr_keep_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $stable(phy_pwr));
endmodule

bind phy_pll_seq phy_pll_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_ack(bus_ack), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .phy_pwr(phy_pwr), .done(done),
  .busy_err(busy_err), .cfg_err(cfg_err)
);

// File: tb/phy_pll_seq_bench.sv
module phy_pll_seq_bench;
  localparam int TICK = 16;
  localparam int POLLS = 100;
  localparam logic [3:0][31:0] T_RATE = {32'd38400000, 32'd26000000, 32'd20000000, 32'd19200000};
  localparam logic [3:0][7:0]  T_N    = {8'd15, 8'd12, 8'd7, 8'd7};
  localparam logic [3:0][11:0] T_M    = {12'd1300, 12'd1250, 12'd1100, 12'd1000};
  localparam logic [3:0][17:0] T_MF   = {18'd200000, 18'd0, 18'd12345, 18'd0};
  localparam logic [3:0][2:0]  T_SEL  = {3'd3, 3'd4, 3'd2, 3'd2};
  localparam logic [3:0][7:0]  T_SD   = {8'd20, 8'd14, 8'd13, 8'd12};

  logic clk = 1'b0, rst = 1'b1, up_req = 1'b0, down_req = 1'b0;
  logic [31:0] ref_hz = '0;
  logic bus_req, bus_we, bus_ack = 1'b0;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = '0, phy_pwr;
  logic done, busy_err, cfg_err;

  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  phy_pll_seq #(
    .ADDR_W(8), .TICK_CYCLES(TICK), .MAX_POLLS(POLLS), .ENTRIES(4),
    .RATES(T_RATE), .DIV_N(T_N), .DIV_M(T_M), .DIV_MF(T_MF), .DCO_SEL(T_SEL), .SD_VAL(T_SD)
  ) u_phy_pll_seq (
    .clk(clk), .rst(rst), .up_req(up_req), .down_req(down_req), .ref_hz(ref_hz),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .phy_pwr(phy_pwr), .done(done),
    .busy_err(busy_err), .cfg_err(cfg_err)
  );

  // ---------------- PLL register model ----------------
  logic [31:0] regs [0:15];
  logic [7:0]  wl_addr [0:511];
  logic [31:0] wl_data [0:511];
  int wcnt = 0, stat_rd = 0, ack_wait = 0, lock_tmr = 0, off_tmr = 0;
  logic lock_en = 1'b1, off_en = 1'b1;

  always @(posedge clk) begin
    if (lock_tmr > 0) begin
      lock_tmr <= lock_tmr - 1;
      if (lock_tmr == 1 && lock_en) regs[1][1] <= 1'b1;
    end
    if (off_tmr > 0) begin
      off_tmr <= off_tmr - 1;
      if (off_tmr == 1 && off_en) begin regs[1][16] <= 1'b1; regs[1][15] <= 1'b1; end
    end
    if (bus_ack) bus_ack <= 1'b0;
    else if (bus_req) begin
      if (ack_wait == 0) begin
        bus_ack <= 1'b1;
        ack_wait <= $urandom_range(0, 3);
        if (bus_we) begin
          regs[bus_addr[5:2]] <= bus_wdata;
          wl_addr[wcnt] <= bus_addr; wl_data[wcnt] <= bus_wdata;
          wcnt <= wcnt + 1;
          if (bus_addr == 8'h08 && bus_wdata[0]) lock_tmr <= 40;
          if (bus_addr == 8'h10) begin
            if (bus_wdata[0]) begin
              regs[1][1] <= 1'b0; regs[1][16] <= 1'b0; regs[1][15] <= 1'b0; off_tmr <= 30;
            end else lock_tmr <= 40;
          end
        end else begin
          bus_rdata <= regs[bus_addr[5:2]];
          if (bus_addr == 8'h04) stat_rd <= stat_rd + 1;
        end
      end else ack_wait <= ack_wait - 1;
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [31:0] fld(input logic [31:0] old, input logic [31:0] v, input int lsb, input int w);
    logic [31:0] mk;
    mk = ((32'h1 << w) - 32'h1) << lsb;
    return (old & ~mk) | ((v << lsb) & mk);
  endfunction

  function automatic logic [31:0] exp_on(input logic [31:0] old, input logic [31:0] r);
    return (old & 32'h0000_3FFF) | (32'h3 << 14) | ((r / 32'd1000000) << 22);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic pulse_up(input logic [31:0] r);
    @(negedge clk); ref_hz = r; up_req = 1'b1;
    @(negedge clk); up_req = 1'b0;
  endtask

  task automatic pulse_down();
    @(negedge clk); down_req = 1'b1;
    @(negedge clk); down_req = 1'b0;
  endtask

  // 1 done, 2 busy error, 3 config error, 0 timeout
  task automatic wait_end(output int kind);
    kind = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin kind = 1; break; end
      if (busy_err) begin kind = 2; break; end
      if (cfg_err) begin kind = 3; break; end
    end
    if (kind == 0) check(1'b0, "watchdog-sequence", 0, 1);
  endtask

  // power-up through the table path with register contents checked
  task automatic up_entry(input int e, input string tag);
    logic [31:0] sh1, sh2, sh3, sh4, w0, exp_w;
    int base, k;
    @(negedge clk);
    regs[1] = 32'h0; lock_en = 1'b1;
    regs[3] = $urandom; regs[4] = $urandom & ~32'd1; regs[5] = $urandom; regs[8] = $urandom;
    sh1 = regs[3]; sh2 = regs[4]; sh3 = regs[5]; sh4 = regs[8];
    w0 = phy_pwr; base = wcnt;
    pulse_up(T_RATE[e]);
    wait_end(k);
    check(k == 1, {tag, " R5 done"}, k, 1);
    check(wcnt - base == 6, {tag, " R3 write count"}, wcnt - base, 6);
    sh1 = fld(sh1, 32'(T_N[e]), 1, 8);
    check(wl_addr[base] == 8'h0C && wl_data[base] == sh1, {tag, " R3 N"}, wl_data[base], sh1);
    sh2 = fld(sh2, 32'(T_SEL[e]), 1, 3);
    check(wl_addr[base+1] == 8'h10 && wl_data[base+1] == sh2, {tag, " R3 DCO"}, wl_data[base+1], sh2);
    sh1 = fld(sh1, 32'(T_M[e]), 9, 12);
    check(wl_addr[base+2] == 8'h0C && wl_data[base+2] == sh1, {tag, " R3 M"}, wl_data[base+2], sh1);
    sh4 = fld(sh4, 32'(T_MF[e]), 0, 18);
    check(wl_addr[base+3] == 8'h20 && wl_data[base+3] == sh4, {tag, " R3 MF"}, wl_data[base+3], sh4);
    sh3 = fld(sh3, 32'(T_SD[e]), 10, 8);
    check(wl_addr[base+4] == 8'h14 && wl_data[base+4] == sh3, {tag, " R3 SD"}, wl_data[base+4], sh3);
    check(wl_addr[base+5] == 8'h08 && wl_data[base+5] == 32'd1, {tag, " R3 go"}, wl_data[base+5], 1);
    exp_w = exp_on(w0, T_RATE[e]);
    check(phy_pwr == exp_w, {tag, " R5 power word"}, phy_pwr, exp_w);
  endtask

  task automatic down_ok(input string tag);
    logic [31:0] c2, w0, exp_w;
    int base, k;
    @(negedge clk);
    off_en = 1'b1; regs[4] = $urandom & ~32'd1; c2 = regs[4];
    w0 = phy_pwr; base = wcnt;
    pulse_down();
    wait_end(k);
    exp_w = w0 & ~32'h003F_C000;
    check(k == 1, {tag, " R7 done"}, k, 1);
    check(phy_pwr == exp_w, {tag, " R7 power word"}, phy_pwr, exp_w);
    check(wcnt - base == 1 && wl_addr[base] == 8'h10 && wl_data[base] == (c2 | 32'd1),
          {tag, " R7 idle write"}, wl_data[base], c2 | 32'd1);
  endtask

  // ---------------- global watchdog ----------------
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int k, base, sr;
    logic [31:0] w0, c2;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) regs[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!bus_req && !done && !busy_err && !cfg_err, "R1 outputs idle", {bus_req, done, busy_err, cfg_err}, 0);
    check(phy_pwr == 32'h0, "R1 power word", phy_pwr, 0);

    // R2 unknown rate
    base = wcnt;
    pulse_up(32'd12345678);
    wait_end(k);
    check(k == 3, "R2 cfg_err pulse", k, 3);
    check(wcnt == base, "R2 no writes", wcnt - base, 0);
    @(negedge clk);
    check(!cfg_err, "R11 cfg_err single cycle", cfg_err, 0);

    // R3/R5 each table entry, then R7 power-down after each
    for (int e = 0; e < 4; e++) begin
      up_entry(e, "dir");
      down_ok("dir");
    end
    // random trials mixing entries and register contents
    for (int t = 0; t < 6; t++) begin
      up_entry($urandom_range(0, 3), "rnd");
      if ($urandom_range(0, 1) == 1) down_ok("rnd");
    end
    down_ok("pre");

    // R4 lock never arrives
    @(negedge clk);
    regs[1] = 32'h0; lock_en = 1'b0; w0 = phy_pwr; sr = stat_rd;
    pulse_up(T_RATE[2]);
    wait_end(k);
    check(k == 2, "R4 busy_err on lock timeout", k, 2);
    check(stat_rd - sr == 1 + POLLS, "R4 poll count", stat_rd - sr, 1 + POLLS);
    check(phy_pwr == w0, "R4 power word kept", phy_pwr, w0);
    lock_en = 1'b1;

    // R6 already locked with idle set: invalid rate proves no lookup
    @(negedge clk);
    regs[1] = 32'h2; regs[4] = $urandom | 32'd1; c2 = regs[4]; base = wcnt; w0 = phy_pwr;
    pulse_up(32'd5);
    wait_end(k);
    check(k == 1, "R6 skip path done", k, 1);
    check(wcnt - base == 1 && wl_addr[base] == 8'h10 && wl_data[base] == (c2 & ~32'd1),
          "R6 idle clear only", wl_data[base], c2 & ~32'd1);
    check(phy_pwr == exp_on(w0, 32'd5), "R6 power word", phy_pwr, exp_on(w0, 32'd5));

    // R6 already locked and not idle: no writes
    @(negedge clk);
    regs[1] = 32'h2; regs[4] = regs[4] & ~32'd1; base = wcnt; w0 = phy_pwr;
    pulse_up(T_RATE[3]);
    wait_end(k);
    check(k == 1 && wcnt == base, "R6 no write when running", wcnt - base, 0);
    check(phy_pwr == exp_on(w0, T_RATE[3]), "R6 word direct", phy_pwr, exp_on(w0, T_RATE[3]));

    // R8 analog parts never report off
    @(negedge clk);
    off_en = 1'b0; sr = stat_rd;
    pulse_down();
    wait_end(k);
    check(k == 2, "R8 busy_err on power-down timeout", k, 2);
    check(stat_rd - sr == POLLS, "R8 poll count", stat_rd - sr, POLLS);
    off_en = 1'b1;

    // R9 requests during a running sequence
    @(negedge clk);
    regs[1] = 32'h0; lock_en = 1'b1; base = wcnt; w0 = phy_pwr;
    pulse_up(T_RATE[1]);
    repeat (5) @(negedge clk);
    pulse_down();
    pulse_up(32'd1);
    wait_end(k);
    check(k == 1, "R9 sequence completes", k, 1);
    check(phy_pwr[21:14] == 8'h03, "R9 command stays on", phy_pwr[21:14], 3);
    repeat (200) @(negedge clk);
    check(wcnt - base == 6 && !bus_req, "R9 no extra activity", wcnt - base, 6);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule